// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This controller sits beside a processor core and decides how deeply the core sleeps and what brings it back. When the core executes a wait-for-interrupt, a wait-for-event, or returns from an interrupt handler with sleep-on-exit armed, the controller samples two configuration bits. These are a deep-sleep enable and a power-down select, and they choose one of three depths. The light sleep gates only the core clock. Stop gates every core-domain clock, turns off both high-speed oscillators and may drop the regulator into low-power mode. Standby also switches the regulator off and is left only through a reset request.

Each depth listens to its own set of wakeup sources. Interrupts are screened by enable and by priority against a threshold. Events are used only by the wait-for-event sleep. External interrupt lines are used only by Stop. The standby sources are a wakeup pin, found by its rising edge, and a vector of RTC, reset and watchdog flags. On leaving Stop the oscillators restart first, and the clocks open only once a ready input confirms they are stable. A sticky flag records that standby was entered. The wakeup reset does not clear it; only an explicit clear strobe does.

Top module: `lp_mode_ctrl`

## Requirements
- R1: After reset, state_o is 0 (run), all four clock and oscillator enables are 1, reg_mode_o is 0 (on), and stby_rst_req_o and stby_flag_o are 0.
- R2: In run with deep-sleep clear, a wait-for-interrupt strobe, or a return strobe while sleep-on-exit is set, moves state_o to 1 (interrupt sleep) on the next edge. A return strobe with sleep-on-exit clear has no effect.
- R3: In run with deep-sleep clear, a wait-for-event strobe alone moves state_o to 2 (event sleep). When the wait-for-interrupt and wait-for-event strobes arrive together, state 1 is chosen.
- R4: In states 1 and 2, core_clk_en_o is 0, while dom_clk_en_o, hsi_en_o and hse_en_o are 1 and reg_mode_o is 0.
- R5: An interrupt qualifies when it is pending, enabled, and its priority value is numerically below prio_thresh_i (a lower value is more urgent). State 1 returns to run on the edge after a qualifying interrupt is seen. Non-qualifying interrupts leave it asleep.
- R6: State 2 returns to run only on the edge after event_i is high. Qualifying interrupts do not wake it.
- R7: With deep-sleep set and power-down clear, an entry moves state_o to 3 (stop). All four enables are then 0, and reg_mode_o is 1 (low-power) if lpreg_sel_i was 1 at entry, otherwise 0.
- R8: In stop, any external line that is both pending and enabled moves state_o to 4 (restart). In restart, hsi_en_o and hse_en_o are 1, both clock enables are 0 and reg_mode_o is 0. The block stays there while osc_rdy_i is 0 and returns to run on the edge after osc_rdy_i is 1. The core clock is never enabled without both oscillators.
- R9: With deep-sleep and power-down both set, an entry moves state_o to 5 (standby). All enables are then 0 and reg_mode_o is 2 (off).
- R10: Standby is left only on a wakeup-pin rising edge (pin 1 now and 0 at the previous edge) or any bit of stby_src_i. The block then goes to run with stby_rst_req_o high for exactly its first run cycle. Events, interrupts and external lines do not wake it.
- R11: A wakeup pin that is already high when standby is entered and stays high does not wake the block.
- R12: stby_flag_o is set on standby entry, stays set after the wakeup reset request, and is cleared only by stby_flag_clr_i. A set and a clear on the same edge leave it set.
- R13: Entry strobes received in any state other than run have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Active-low reset |
| wfi_i | input | 1 | Wait-for-interrupt strobe |
| wfe_i | input | 1 | Wait-for-event strobe |
| eret_i | input | 1 | Return-from-interrupt strobe |
| sleep_on_exit_i | input | 1 | Arms entry on return from interrupt |
| deep_sleep_i | input | 1 | Selects stop or standby rather than light sleep |
| pdown_sel_i | input | 1 | With deep sleep, selects standby over stop |
| lpreg_sel_i | input | 1 | Low-power regulator in stop |
| irq_pend_i | input | NIRQ | Pending interrupts |
| irq_en_i | input | NIRQ | Interrupt enables |
| irq_prio_i | input | NIRQ*PRIO_W | Packed priority values, interrupt k at bits k*PRIO_W upward |
| prio_thresh_i | input | PRIO_W | Current priority threshold |
| event_i | input | 1 | Wakeup event |
| exti_pend_i | input | NEXTI | External interrupt lines pending |
| exti_en_i | input | NEXTI | External interrupt line enables |
| wkup_pin_i | input | 1 | Standby wakeup pin |
| stby_src_i | input | NSTBY | Standby sources: RTC alarm A, alarm B, RTC wakeup, tamper, timestamp, external reset, watchdog reset |
| osc_rdy_i | input | 1 | Oscillators stable after restart |
| stby_flag_clr_i | input | 1 | Clears the standby flag |
| core_clk_en_o | output | 1 | Core clock gate enable |
| dom_clk_en_o | output | 1 | Core-domain clock gate enable |
| hsi_en_o | output | 1 | Internal high-speed oscillator enable |
| hse_en_o | output | 1 | External high-speed oscillator enable |
| reg_mode_o | output | 2 | Regulator: 0 on, 1 low-power, 2 off |
| stby_rst_req_o | output | 1 | One-cycle reset request on standby wakeup |
| stby_flag_o | output | 1 | Standby-was-entered flag |
| state_o | output | 3 | 0 run, 1 interrupt sleep, 2 event sleep, 3 stop, 4 restart, 5 standby |

## Verification
The assertions check the following on every cycle:
- each sleep state holds until its own wake signal arrives, using the separately computed interrupt, line and standby wake wires;
- a light-sleep entry lands in state 1;
- the core clock never runs without both oscillators, and stays gated while restart waits for ready;
- the reset request appears only in the first cycle after standby;
- the flag falls only after a clear.

Only the bench scenarios can show the following:
- wake sources that belong to one depth being ignored in another;
- the pin held high through standby entry;
- the regulator choice latched at stop entry;
- the flag surviving the wakeup.

// File: rtl/lp_mode_pkg.sv
package lp_mode_pkg;

  typedef enum logic [2:0] {
    LPM_RUN     = 3'd0,
    LPM_SLP_IRQ = 3'd1,
    LPM_SLP_EVT = 3'd2,
    LPM_STOP    = 3'd3,
    LPM_RESTART = 3'd4,
    LPM_STBY    = 3'd5
  } lpm_state_e;

  typedef enum logic [1:0] {
    REG_ON     = 2'd0,
    REG_LOWPWR = 2'd1,
    REG_OFF    = 2'd2
  } reg_mode_e;

  typedef enum logic [1:0] {
    DEPTH_LIGHT = 2'd0,
    DEPTH_STOP  = 2'd1,
    DEPTH_STBY  = 2'd2
  } depth_e;

  typedef struct packed {
    logic      core_clk;
    logic      dom_clk;
    logic      hsi;
    logic      hse;
    reg_mode_e reg_mode;
  } lpm_outs_t;

  // Depth chosen from the two configuration bits at entry time.
  function automatic depth_e pick_depth(input logic deep, input logic pdown);
    if (!deep)      return DEPTH_LIGHT;
    else if (pdown) return DEPTH_STBY;
    else            return DEPTH_STOP;
  endfunction

  // Gate and regulator settings seen in each state.
  function automatic lpm_outs_t outs_for(input lpm_state_e s, input logic stop_lp);
    lpm_outs_t o;
    o.core_clk = 1'b1;
    o.dom_clk  = 1'b1;
    o.hsi      = 1'b1;
    o.hse      = 1'b1;
    o.reg_mode = REG_ON;
    unique case (s)
      LPM_SLP_IRQ, LPM_SLP_EVT: o.core_clk = 1'b0;
      LPM_STOP: begin
        o.core_clk = 1'b0;
        o.dom_clk  = 1'b0;
        o.hsi      = 1'b0;
        o.hse      = 1'b0;
        o.reg_mode = stop_lp ? REG_LOWPWR : REG_ON;
      end
      LPM_RESTART: begin
        o.core_clk = 1'b0;
        o.dom_clk  = 1'b0;
      end
      LPM_STBY: begin
        o.core_clk = 1'b0;
        o.dom_clk  = 1'b0;
        o.hsi      = 1'b0;
        o.hse      = 1'b0;
        o.reg_mode = REG_OFF;
      end
      default: ;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/lp_irq_qualify.sv
module lp_irq_qualify #(
  parameter int NIRQ   = 8,
  parameter int PRIO_W = 4
) (
  input  logic [NIRQ-1:0]        pend_i,
  input  logic [NIRQ-1:0]        en_i,
  input  logic [NIRQ*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]      thresh_i,
  output logic                   wake_o
);

  // Lower numeric value means more urgent; the threshold itself is masked.
  function automatic logic prio_beats(input logic [PRIO_W-1:0] p,
                                      input logic [PRIO_W-1:0] t);
    return p < t;
  endfunction

  logic [NIRQ-1:0] qual_w;

  for (genvar k = 0; k < NIRQ; k++) begin : g_irq
    assign qual_w[k] = pend_i[k] & en_i[k] &
                       prio_beats(prio_i[k*PRIO_W +: PRIO_W], thresh_i);
  end

  assign wake_o = |qual_w;

endmodule

// File: rtl/lp_wake_detect.sv
module lp_wake_detect #(
  parameter int NEXTI = 8,
  parameter int NSTBY = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NEXTI-1:0] exti_pend_i,
  input  logic [NEXTI-1:0] exti_en_i,
  input  logic             pin_i,
  input  logic [NSTBY-1:0] stby_src_i,
  output logic             exti_wake_o,
  output logic             stby_wake_o
);

  logic pin_q;
  logic pin_rise_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_i;
  end

  assign pin_rise_w  = pin_i & ~pin_q;
  assign exti_wake_o = |(exti_pend_i & exti_en_i);
  assign stby_wake_o = pin_rise_w | (|stby_src_i);

endmodule

// File: rtl/lp_mode_fsm.sv
module lp_mode_fsm
  import lp_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wfi_i,
  input  logic       wfe_i,
  input  logic       eret_i,
  input  logic       sleep_on_exit_i,
  input  logic       deep_sleep_i,
  input  logic       pdown_sel_i,
  input  logic       lpreg_sel_i,
  input  logic       irq_wake_i,
  input  logic       event_i,
  input  logic       exti_wake_i,
  input  logic       stby_wake_i,
  input  logic       osc_rdy_i,
  input  logic       flag_clr_i,
  output lpm_state_e state_o,
  output logic       stop_lp_o,
  output logic       rst_req_o,
  output logic       flag_o
);

  lpm_state_e state_q, state_d;
  logic       stop_lp_q;
  logic       rst_req_q;
  logic       flag_q;
  logic       ret_entry_w;
  logic       entry_w;
  logic       evt_only_w;
  depth_e     depth_w;
  logic       go_stop_w;
  logic       go_stby_w;
  logic       leave_stby_w;

  assign ret_entry_w = eret_i & sleep_on_exit_i;
  assign entry_w     = wfi_i | wfe_i | ret_entry_w;
  assign evt_only_w  = wfe_i & ~wfi_i & ~ret_entry_w;
  assign depth_w     = pick_depth(deep_sleep_i, pdown_sel_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LPM_RUN: begin
        if (entry_w) begin
          unique case (depth_w)
            DEPTH_LIGHT: state_d = evt_only_w ? LPM_SLP_EVT : LPM_SLP_IRQ;
            DEPTH_STOP:  state_d = LPM_STOP;
            default:     state_d = LPM_STBY;
          endcase
        end
      end
      LPM_SLP_IRQ: if (irq_wake_i)  state_d = LPM_RUN;
      LPM_SLP_EVT: if (event_i)     state_d = LPM_RUN;
      LPM_STOP:    if (exti_wake_i) state_d = LPM_RESTART;
      LPM_RESTART: if (osc_rdy_i)   state_d = LPM_RUN;
      LPM_STBY:    if (stby_wake_i) state_d = LPM_RUN;
      default:     state_d = LPM_RUN;
    endcase
  end

  assign go_stop_w    = (state_q == LPM_RUN) && (state_d == LPM_STOP);
  assign go_stby_w    = (state_q == LPM_RUN) && (state_d == LPM_STBY);
  assign leave_stby_w = (state_q == LPM_STBY) && (state_d == LPM_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= LPM_RUN;
      stop_lp_q <= 1'b0;
      rst_req_q <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      rst_req_q <= leave_stby_w;
      if (go_stop_w)  stop_lp_q <= lpreg_sel_i;
      if (flag_clr_i) flag_q    <= 1'b0;
      if (go_stby_w)  flag_q    <= 1'b1;
    end
  end

  assign state_o   = state_q;
  assign stop_lp_o = stop_lp_q;
  assign rst_req_o = rst_req_q;
  assign flag_o    = flag_q;

endmodule

// File: rtl/lp_mode_ctrl.sv
module lp_mode_ctrl
  import lp_mode_pkg::*;
#(
  parameter int NIRQ   = 8,
  parameter int PRIO_W = 4,
  parameter int NEXTI  = 8,
  parameter int NSTBY  = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wfi_i,
  input  logic                   wfe_i,
  input  logic                   eret_i,
  input  logic                   sleep_on_exit_i,
  input  logic                   deep_sleep_i,
  input  logic                   pdown_sel_i,
  input  logic                   lpreg_sel_i,
  input  logic [NIRQ-1:0]        irq_pend_i,
  input  logic [NIRQ-1:0]        irq_en_i,
  input  logic [NIRQ*PRIO_W-1:0] irq_prio_i,
  input  logic [PRIO_W-1:0]      prio_thresh_i,
  input  logic                   event_i,
  input  logic [NEXTI-1:0]       exti_pend_i,
  input  logic [NEXTI-1:0]       exti_en_i,
  input  logic                   wkup_pin_i,
  input  logic [NSTBY-1:0]       stby_src_i,
  input  logic                   osc_rdy_i,
  input  logic                   stby_flag_clr_i,
  output logic                   core_clk_en_o,
  output logic                   dom_clk_en_o,
  output logic                   hsi_en_o,
  output logic                   hse_en_o,
  output logic [1:0]             reg_mode_o,
  output logic                   stby_rst_req_o,
  output logic                   stby_flag_o,
  output logic [2:0]             state_o
);

  logic       irq_wake_w;
  logic       exti_wake_w;
  logic       stby_wake_w;
  lpm_state_e state_w;
  logic       stop_lp_w;
  lpm_outs_t  outs_w;

  lp_irq_qualify #(.NIRQ(NIRQ), .PRIO_W(PRIO_W)) u_irq (
    .pend_i   (irq_pend_i),
    .en_i     (irq_en_i),
    .prio_i   (irq_prio_i),
    .thresh_i (prio_thresh_i),
    .wake_o   (irq_wake_w)
  );

  lp_wake_detect #(.NEXTI(NEXTI), .NSTBY(NSTBY)) u_wake (
    .clk         (clk),
    .rst_n       (rst_n),
    .exti_pend_i (exti_pend_i),
    .exti_en_i   (exti_en_i),
    .pin_i       (wkup_pin_i),
    .stby_src_i  (stby_src_i),
    .exti_wake_o (exti_wake_w),
    .stby_wake_o (stby_wake_w)
  );

  lp_mode_fsm u_fsm (
    .clk             (clk),
    .rst_n           (rst_n),
    .wfi_i           (wfi_i),
    .wfe_i           (wfe_i),
    .eret_i          (eret_i),
    .sleep_on_exit_i (sleep_on_exit_i),
    .deep_sleep_i    (deep_sleep_i),
    .pdown_sel_i     (pdown_sel_i),
    .lpreg_sel_i     (lpreg_sel_i),
    .irq_wake_i      (irq_wake_w),
    .event_i         (event_i),
    .exti_wake_i     (exti_wake_w),
    .stby_wake_i     (stby_wake_w),
    .osc_rdy_i       (osc_rdy_i),
    .flag_clr_i      (stby_flag_clr_i),
    .state_o         (state_w),
    .stop_lp_o       (stop_lp_w),
    .rst_req_o       (stby_rst_req_o),
    .flag_o          (stby_flag_o)
  );

  assign outs_w        = outs_for(state_w, stop_lp_w);
  assign core_clk_en_o = outs_w.core_clk;
  assign dom_clk_en_o  = outs_w.dom_clk;
  assign hsi_en_o      = outs_w.hsi;
  assign hse_en_o      = outs_w.hse;
  assign reg_mode_o    = outs_w.reg_mode;
  assign state_o       = state_w;

endmodule

// File: rtl/lp_mode_ctrl_chk.sv
module lp_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] st,
  input logic       wfi,
  input logic       wfe,
  input logic       eret,
  input logic       soe,
  input logic       deep,
  input logic       pdown,
  input logic       evt,
  input logic       irq_wake,
  input logic       exti_wake,
  input logic       stby_wake,
  input logic       osc_rdy,
  input logic       clr,
  input logic       core_en,
  input logic       hsi_en,
  input logic       hse_en,
  input logic [1:0] reg_mode,
  input logic       rst_req,
  input logic       flag
);

  logic entry;
  assign entry = wfi | wfe | (eret & soe);

  assert_light_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 && wfi && !deep) |=> st == 3'd1);

  assert_irq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd1 && !irq_wake) |=> st == 3'd1);

  assert_irq_leave_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd1 && irq_wake) |=> st == 3'd0);

  assert_evt_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd2 && !evt) |=> st == 3'd2);

  assert_stop_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd3 && !exti_wake) |=> st == 3'd3);

  assert_restart_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd4 && !osc_rdy) |=> !core_en);

  assert_core_needs_osc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    core_en |-> (hsi_en && hse_en));

  assert_stby_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 && entry && deep && pdown) |=> (reg_mode == 2'd2 && flag));

  assert_stby_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd5 && !stby_wake) |=> st == 3'd5);

  assert_rst_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ($past(st) == 3'd5 && st == 3'd0));

  assert_flag_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(clr));

endmodule

bind lp_mode_ctrl lp_mode_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .st        (state_o),
  .wfi       (wfi_i),
  .wfe       (wfe_i),
  .eret      (eret_i),
  .soe       (sleep_on_exit_i),
  .deep      (deep_sleep_i),
  .pdown     (pdown_sel_i),
  .evt       (event_i),
  .irq_wake  (irq_wake_w),
  .exti_wake (exti_wake_w),
  .stby_wake (stby_wake_w),
  .osc_rdy   (osc_rdy_i),
  .clr       (stby_flag_clr_i),
  .core_en   (core_clk_en_o),
  .hsi_en    (hsi_en_o),
  .hse_en    (hse_en_o),
  .reg_mode  (reg_mode_o),
  .rst_req   (stby_rst_req_o),
  .flag      (stby_flag_o)
);

// File: tb/lp_mode_ctrl_bench.sv
`timescale 1ns/1ps
module lp_mode_ctrl_bench;

  localparam int NIRQ = 8, PW = 4, NEXTI = 8, NSTBY = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wfi = 0, wfe = 0, eret = 0, soe = 0, deep = 0, pdown = 0, lpreg = 0;
  logic [NIRQ-1:0] ipend = '0, ien = '0;
  logic [NIRQ*PW-1:0] iprio = '0;
  logic [PW-1:0] thresh = '0;
  logic evt = 0, pin = 0, rdy = 0, clr = 0;
  logic [NEXTI-1:0] xpend = '0, xen = '0;
  logic [NSTBY-1:0] src = '0;
  logic core, dom, hsi, hse, req, flag;
  logic [1:0] regm;
  logic [2:0] st;

  always #10 clk = ~clk;

  lp_mode_ctrl u_lp_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .wfi_i(wfi), .wfe_i(wfe), .eret_i(eret),
    .sleep_on_exit_i(soe), .deep_sleep_i(deep), .pdown_sel_i(pdown),
    .lpreg_sel_i(lpreg), .irq_pend_i(ipend), .irq_en_i(ien), .irq_prio_i(iprio),
    .prio_thresh_i(thresh), .event_i(evt), .exti_pend_i(xpend), .exti_en_i(xen),
    .wkup_pin_i(pin), .stby_src_i(src), .osc_rdy_i(rdy), .stby_flag_clr_i(clr),
    .core_clk_en_o(core), .dom_clk_en_o(dom), .hsi_en_o(hsi), .hse_en_o(hse),
    .reg_mode_o(regm), .stby_rst_req_o(req), .stby_flag_o(flag), .state_o(st)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  string tag = "R1";

  // Behavioural reference model
  int m_mode = 0;
  bit m_lp = 0, m_req = 0, m_flag = 0, m_pin = 0;
  int m_next;
  bit m_irq, m_line, m_sb, m_ent;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_lp = 0; m_req = 0; m_flag = 0; m_pin = 0;
    end else begin
      m_irq = 0;
      for (int k = 0; k < NIRQ; k++)
        if (ipend[k] && ien[k] && (int'(iprio[k*PW +: PW]) < int'(thresh))) m_irq = 1;
      m_line = (xpend & xen) != 0;
      m_sb   = (pin && !m_pin) || (src != 0);
      m_ent  = wfi || wfe || (eret && soe);
      m_next = m_mode;
      m_req  = 0;
      if (clr) m_flag = 0;
      case (m_mode)
        0: if (m_ent) begin
             if (!deep) m_next = (wfi || (eret && soe)) ? 1 : 2;
             else if (!pdown) begin m_next = 3; m_lp = lpreg; end
             else begin m_next = 5; m_flag = 1; end
           end
        1: if (m_irq) m_next = 0;
        2: if (evt) m_next = 0;
        3: if (m_line) m_next = 4;
        4: if (rdy) m_next = 0;
        5: if (m_sb) begin m_next = 0; m_req = 1; end
        default: m_next = 0;
      endcase
      m_mode = m_next;
      m_pin  = pin;
    end
  end

  task automatic check(input bit ok, input string req_s, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req_s, what, act, exp);
    end
  endtask

  function automatic int exp_gates(input int m);
    // bits: core, dom, hsi, hse
    case (m)
      0: return 4'b1111;
      1, 2: return 4'b0111;
      4: return 4'b0011;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic int exp_reg(input int m, input bit lp);
    if (m == 5) return 2;
    if (m == 3 && lp) return 1;
    return 0;
  endfunction

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(int'(st) == m_mode, tag, "state", int'(st), m_mode);
      check(int'({core, dom, hsi, hse}) == exp_gates(m_mode), tag, "gates",
            int'({core, dom, hsi, hse}), exp_gates(m_mode));
      check(int'(regm) == exp_reg(m_mode, m_lp), tag, "regulator",
            int'(regm), exp_reg(m_mode, m_lp));
      check(req == m_req, tag, "reset request", int'(req), int'(m_req));
      check(flag == m_flag, tag, "flag", int'(flag), int'(m_flag));
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 20000);
      finish_run();
    end
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    // R1 reset state
    check(st == 3'd0 && core && dom && hsi && hse && regm == 2'd0 && !req && !flag,
          "R1", "reset outputs", int'(st), 0);

    // R2 wfi -> interrupt sleep; R4 gates
    tag = "R2"; wfi = 1; step(); wfi = 0;
    check(st == 3'd1, "R2", "wfi sleep", int'(st), 1);
    check(!core && dom && hsi && hse && regm == 0, "R4", "sleep gates", int'(core), 0);
    // R5 non-qualifying interrupt (prio equal to threshold)
    tag = "R5"; iprio[3*PW +: PW] = 4'd5; thresh = 4'd5; ipend[3] = 1; ien[3] = 1;
    step(3);
    check(st == 3'd1, "R5", "masked irq ignored", int'(st), 1);
    thresh = 4'd6; step();
    check(st == 3'd0, "R5", "qualifying irq wakes", int'(st), 0);
    ipend = '0;

    // R2 return without sleep-on-exit ignored, then with it
    tag = "R2"; eret = 1; step(); eret = 0; step();
    check(st == 3'd0, "R2", "eret without soe", int'(st), 0);
    soe = 1; eret = 1; step(); eret = 0; soe = 0;
    check(st == 3'd1, "R2", "eret with soe", int'(st), 1);
    ien[3] = 0; ipend[3] = 1; step(2);
    check(st == 3'd1, "R5", "disabled irq ignored", int'(st), 1);
    ien[3] = 1; step(); ipend = '0;
    check(st == 3'd0, "R5", "enabled irq wakes", int'(st), 0);

    // R3 wfe -> event sleep; R6 only event wakes
    tag = "R3"; wfe = 1; step(); wfe = 0;
    check(st == 3'd2, "R3", "wfe sleep", int'(st), 2);
    tag = "R6"; ipend[3] = 1; step(3);
    check(st == 3'd2 && !core, "R6", "irq ignored in event sleep", int'(st), 2);
    ipend = '0; evt = 1; step(); evt = 0;
    check(st == 3'd0, "R6", "event wakes", int'(st), 0);
    tag = "R3"; wfi = 1; wfe = 1; step(); wfi = 0; wfe = 0;
    check(st == 3'd1, "R3", "wfi wins over wfe", int'(st), 1);
    evt = 1; step(); evt = 0;
    check(st == 3'd1, "R5", "event ignored in irq sleep", int'(st), 1);
    ipend[3] = 1; step(); ipend = '0;

    // R7 stop with low-power regulator
    tag = "R7"; deep = 1; lpreg = 1; wfi = 1; step(); wfi = 0; lpreg = 0;
    check(st == 3'd3 && {core, dom, hsi, hse} == 4'b0000 && regm == 2'd1,
          "R7", "stop low-power", int'(regm), 1);
    // R13 entry in stop ignored
    tag = "R13"; deep = 0; wfi = 1; wfe = 1; step(); wfi = 0; wfe = 0; deep = 1;
    check(st == 3'd3, "R13", "entry outside run", int'(st), 3);
    // R8 line pending but not enabled
    tag = "R8"; xpend[5] = 1; ipend[3] = 1; evt = 1; step(2); evt = 0; ipend = '0;
    check(st == 3'd3, "R8", "disabled line ignored", int'(st), 3);
    xen[5] = 1; step(); xpend = '0; xen = '0;
    check(st == 3'd4 && hsi && hse && !core && !dom && regm == 0,
          "R8", "restart oscillators first", int'(st), 4);
    step(3);
    check(st == 3'd4 && !core, "R8", "wait for ready", int'(st), 4);
    rdy = 1; step(); rdy = 0;
    check(st == 3'd0 && core, "R8", "ready opens clocks", int'(st), 0);
    // R7 stop with regulator on, via wfe
    tag = "R7"; wfe = 1; step(); wfe = 0;
    check(st == 3'd3 && regm == 2'd0, "R7", "stop regulator on", int'(regm), 0);
    xpend[0] = 1; xen[0] = 1; rdy = 1; step(2); xpend = '0; xen = '0; rdy = 0;
    check(st == 3'd0, "R8", "stop exit", int'(st), 0);

    // R9/R11 standby with pin already high
    tag = "R11"; pin = 1; step(2);
    pdown = 1; wfi = 1; step(); wfi = 0;
    check(st == 3'd5 && regm == 2'd2 && {core, dom, hsi, hse} == 4'b0000,
          "R9", "standby entry", int'(regm), 2);
    check(flag, "R12", "flag set on entry", int'(flag), 1);
    step(3);
    check(st == 3'd5, "R11", "held pin no wake", int'(st), 5);
    tag = "R10"; evt = 1; ipend[3] = 1; xpend[2] = 1; xen[2] = 1; step(2);
    evt = 0; ipend = '0; xpend = '0; xen = '0;
    check(st == 3'd5, "R10", "other sources ignored", int'(st), 5);
    pin = 0; step();
    check(st == 3'd5, "R10", "pin fall no wake", int'(st), 5);
    pin = 1; step();
    check(st == 3'd0 && req, "R10", "pin rise wakes with reset", int'(req), 1);
    step();
    check(!req, "R10", "reset request one cycle", int'(req), 0);
    check(flag, "R12", "flag survives wakeup", int'(flag), 1);
    pin = 0;
    tag = "R12"; clr = 1; step(); clr = 0;
    check(!flag, "R12", "flag cleared", int'(flag), 0);

    // R10 source vector wakes; R12 set wins over clear
    tag = "R12"; soe = 1; eret = 1; clr = 1; step(); eret = 0; soe = 0; clr = 0;
    check(st == 3'd5 && flag, "R12", "set beats clear", int'(flag), 1);
    tag = "R10"; src[3] = 1; step(); src = '0;
    check(st == 3'd0 && req, "R10", "source bit wakes", int'(st), 0);
    deep = 0; pdown = 0; step(2);

    finish_run();
  end

endmodule